// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of one 16-bit, two-bank SDRAM device (11 row bits, 8 column bits, one bank-address bit, 2048 rows). After a synchronous reset it brings the device up in a fixed order. First comes a stretch of NOP cycles with the clock enable high, long enough to cover the device's 200 µs power-up settling time. A precharge-all follows. The sequencer then issues a fixed number of closely spaced auto-refresh commands and finally loads the mode register. Only after that does it raise a completion flag.

Once the flag is up, a free-running timer issues one auto-refresh for every interval of 16 × N clocks. N is a software-provided count: at a 60 MHz memory clock, N = 57 keeps the spacing under 15.625 µs (32 ms across 2048 rows). Every wait between commands is given in clock cycles at the ports. The mode word is built from a CAS latency and a burst-length code and is driven on the address pins. Chip select is held asserted because the block serves a single device. Read and write traffic are handled elsewhere.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: Cycle 0 is the cycle after the last clock edge at which `rst` is high. In cycle 0 `cke` is low, the command is NOP, `addr` is 0 and `initDone` is low. `cke` is high from cycle 1 onward until the next reset.
- R2: With P = `powerUpCycles` (0 is treated as 1), cycles 1..P carry NOP with `cke` high. The first non-NOP command appears in cycle P+1.
- R3: A command is encoded on {`rasN`,`casN`,`weN`} with `csN` low: NOP = 111, precharge = 010, auto-refresh = 001, mode-load = 000. The command in cycle P+1 is precharge with `addr` = 0x400 (bit 10 high, all other bits 0) and `ba` = 0.
- R4: After the precharge, exactly `tRpCycles` NOP cycles pass, and then the first auto-refresh appears (`addr` = 0).
- R5: During initialization exactly INIT_REFRESHES auto-refresh commands (default 8) are issued. Each one is followed by G NOP cycles, where G = max(`tRfcCycles`, 15), so consecutive refreshes are at least one 16-clock unit apart.
- R6: The mode-load command follows the G NOP cycles after the last initialization refresh. It carries `addr`[2:0] = `burstCode`, `addr`[6:4] = `casLatency` and all other address bits 0 (CAS 2, burst code 3 gives 0x023), with `ba` = 0.
- R7: After the mode-load, exactly `tMrdCycles` NOP cycles pass. `initDone` rises in the next cycle, D, which is itself a NOP, and stays high until reset.
- R8: With R = `refInterval` non-zero, auto-refresh appears in cycles D + 16·R·k for k ≥ 1, with `addr` = 0, and NOP in every other cycle from D on.
- R9: With `refInterval` = 0, every cycle from D on carries NOP.
- R10: A reset asserted in normal operation, including on the edge that would launch a periodic refresh, suppresses that refresh. It gives the cycle-0 state of R1 and then replays the whole power-up order.
- R11: `csN` is low in every cycle, and no encoding other than the four in R3 ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| powerUpCycles | input | 16 | NOP cycles with clock enable high before the precharge |
| tRpCycles | input | 8 | NOP cycles after the precharge |
| tRfcCycles | input | 8 | Requested NOP cycles after each initialization refresh (floored at 15) |
| tMrdCycles | input | 8 | NOP cycles after the mode-load |
| refInterval | input | 12 | Periodic refresh spacing in units of 16 clocks; 0 disables refresh |
| casLatency | input | 3 | CAS latency field of the mode word |
| burstCode | input | 3 | Burst-length code of the mode word |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | 11 | SDRAM address pins |
| ba | output | 1 | SDRAM bank address |
| initDone | output | 1 | High once the power-up order has completed |

## Verification
Two things can fall on the same edge: a periodic refresh becoming due and a synchronous reset. The bench first follows a run with a one-unit interval up to the cycle just before the second periodic refresh. It then raises reset for exactly the edge that would launch that refresh. That cycle must show CKE low, NOP and a cleared completion flag rather than an auto-refresh, and the entire power-up timeline must then replay cycle for cycle. Outside that case, the bench computes every cycle's expected pin tuple arithmetically from the wait counts, across a grid of power-up, precharge, refresh-gap, mode-wait and interval values.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  // {rasN, casN, weN} with chip select asserted
  typedef enum logic [2:0] {
    CMD_MODE      = 3'b000,
    CMD_REFRESH   = 3'b001,
    CMD_PRECHARGE = 3'b010,
    CMD_NOP       = 3'b111
  } sdCmd_e;

  typedef enum logic [1:0] {
    WAIT_POWERUP   = 2'd0,
    WAIT_PRECHARGE = 2'd1,
    WAIT_REFRESH   = 2'd2,
    WAIT_MODE      = 2'd3
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    sdCmd_e   cmd;
    logic     loadWait;
    waitSel_e waitSel;
    logic     decWait;
    logic     runMode;
  } seqStrobe_t;

  localparam int unsigned REFRESH_UNIT = 16;
  localparam int unsigned UNIT_SHIFT   = 4;

endpackage

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int unsigned INIT_REFRESHES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       waitZero,
  input  logic       waitLast,
  input  logic       refTick,
  output seqStrobe_t strobe
);

  localparam int unsigned RC_W = $clog2(INIT_REFRESHES + 1);

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_PRECHARGE,
    ST_WAIT_RP,
    ST_REFRESH,
    ST_WAIT_RFC,
    ST_MODE,
    ST_WAIT_MRD,
    ST_RUN
  } state_e;

  state_e          state;
  state_e          stateNext;
  logic [RC_W-1:0] refCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_POWERUP;
      refCount <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_REFRESH) refCount <= refCount + RC_W'(1);
    end
  end

  always_comb begin
    stateNext        = state;
    strobe.cmd       = CMD_NOP;
    strobe.loadWait  = 1'b0;
    strobe.waitSel   = WAIT_POWERUP;
    strobe.decWait   = 1'b0;
    strobe.runMode   = 1'b0;
    case (state)
      ST_POWERUP: begin
        strobe.decWait = 1'b1;
        if (waitLast) stateNext = ST_PRECHARGE;
      end
      ST_PRECHARGE: begin
        strobe.cmd      = CMD_PRECHARGE;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_PRECHARGE;
        stateNext       = waitZero ? ST_REFRESH : ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        strobe.decWait = 1'b1;
        if (waitLast) stateNext = ST_REFRESH;
      end
      ST_REFRESH: begin
        strobe.cmd      = CMD_REFRESH;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_REFRESH;
        stateNext       = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        strobe.decWait = 1'b1;
        if (waitLast)
          stateNext = (refCount == RC_W'(INIT_REFRESHES)) ? ST_MODE : ST_REFRESH;
      end
      ST_MODE: begin
        strobe.cmd      = CMD_MODE;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_MODE;
        stateNext       = waitZero ? ST_RUN : ST_WAIT_MRD;
      end
      ST_WAIT_MRD: begin
        strobe.decWait = 1'b1;
        if (waitLast) stateNext = ST_RUN;
      end
      ST_RUN: begin
        strobe.runMode = 1'b1;
        strobe.cmd     = refTick ? CMD_REFRESH : CMD_NOP;
      end
      default: stateNext = ST_POWERUP;
    endcase
  end

endmodule

// File: rtl/sdram_seq_datapath.sv
`timescale 1ns/1ps
module sdram_seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int unsigned PWR_W  = 16,
  parameter int unsigned TIM_W  = 8,
  parameter int unsigned REF_W  = 12,
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned AP_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [PWR_W-1:0] powerUpCycles,
  input  logic [TIM_W-1:0] tRpCycles,
  input  logic [TIM_W-1:0] tRfcCycles,
  input  logic [TIM_W-1:0] tMrdCycles,
  input  logic [REF_W-1:0] refInterval,
  input  logic [2:0]       casLatency,
  input  logic [2:0]       burstCode,
  output logic             waitZero,
  output logic             waitLast,
  output logic             refTick,
  output logic             cke,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] addr,
  output logic             initDone
);

  localparam int unsigned TMR_W = REF_W + UNIT_SHIFT;
  localparam logic [TIM_W-1:0] MIN_RFC_GAP = TIM_W'(REFRESH_UNIT - 1);

  logic [PWR_W-1:0] waitCnt;
  logic [PWR_W-1:0] loadVal;
  logic [TIM_W-1:0] rfcGap;
  logic [TMR_W-1:0] refTimer;
  logic [TMR_W-1:0] refLimit;
  logic             refEnable;
  logic [ROW_W-1:0] modeWord;
  logic [ROW_W-1:0] nextAddr;

  // wait counter shared by every initialization step
  always_comb begin
    rfcGap = (tRfcCycles > MIN_RFC_GAP) ? tRfcCycles : MIN_RFC_GAP;
    case (strobe.waitSel)
      WAIT_POWERUP:   loadVal = powerUpCycles;
      WAIT_PRECHARGE: loadVal = PWR_W'(tRpCycles);
      WAIT_REFRESH:   loadVal = PWR_W'(rfcGap);
      default:        loadVal = PWR_W'(tMrdCycles);
    endcase
  end

  assign waitZero = (loadVal == '0);
  assign waitLast = (waitCnt <= PWR_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                                waitCnt <= powerUpCycles;
    else if (strobe.loadWait)               waitCnt <= loadVal;
    else if (strobe.decWait && waitCnt != '0) waitCnt <= waitCnt - PWR_W'(1);
  end

  // periodic refresh timer: one tick every 16 * refInterval clocks
  assign refEnable = (refInterval != '0);
  assign refLimit  = {refInterval - REF_W'(1), 4'hF};
  assign refTick   = initDone && refEnable && (refTimer >= refLimit);

  always_ff @(posedge clk) begin
    if (rst || !initDone) refTimer <= '0;
    else if (refTick)     refTimer <= '0;
    else                  refTimer <= refTimer + TMR_W'(1);
  end

  // address pins
  always_comb begin
    modeWord      = '0;
    modeWord[2:0] = burstCode;
    modeWord[6:4] = casLatency;
    nextAddr      = '0;
    case (strobe.cmd)
      CMD_PRECHARGE: nextAddr[AP_BIT] = 1'b1;
      CMD_MODE:      nextAddr = modeWord;
      default:       nextAddr = '0;
    endcase
  end

  // registered pins
  always_ff @(posedge clk) begin
    if (rst) begin
      cke              <= 1'b0;
      {rasN,casN,weN}  <= CMD_NOP;
      addr             <= '0;
      initDone         <= 1'b0;
    end else begin
      cke              <= 1'b1;
      {rasN,casN,weN}  <= strobe.cmd;
      addr             <= nextAddr;
      initDone         <= strobe.runMode;
    end
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned PWR_W          = 16,
  parameter int unsigned TIM_W          = 8,
  parameter int unsigned REF_W          = 12,
  parameter int unsigned ROW_W          = 11,
  parameter int unsigned AP_BIT         = 10,
  parameter int unsigned INIT_REFRESHES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWR_W-1:0] powerUpCycles,
  input  logic [TIM_W-1:0] tRpCycles,
  input  logic [TIM_W-1:0] tRfcCycles,
  input  logic [TIM_W-1:0] tMrdCycles,
  input  logic [REF_W-1:0] refInterval,
  input  logic [2:0]       casLatency,
  input  logic [2:0]       burstCode,
  output logic             cke,
  output logic             csN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] addr,
  output logic             ba,
  output logic             initDone
);

  seqStrobe_t strobe;
  logic       waitZero;
  logic       waitLast;
  logic       refTick;

  // single device, bank 0 for every command this block issues
  assign csN = 1'b0;
  assign ba  = 1'b0;

  sdram_seq_ctrl #(
    .INIT_REFRESHES(INIT_REFRESHES)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .waitZero (waitZero),
    .waitLast (waitLast),
    .refTick  (refTick),
    .strobe   (strobe)
  );

  sdram_seq_datapath #(
    .PWR_W  (PWR_W),
    .TIM_W  (TIM_W),
    .REF_W  (REF_W),
    .ROW_W  (ROW_W),
    .AP_BIT (AP_BIT)
  ) dp_i (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .powerUpCycles (powerUpCycles),
    .tRpCycles     (tRpCycles),
    .tRfcCycles    (tRfcCycles),
    .tMrdCycles    (tMrdCycles),
    .refInterval   (refInterval),
    .casLatency    (casLatency),
    .burstCode     (burstCode),
    .waitZero      (waitZero),
    .waitLast      (waitLast),
    .refTick       (refTick),
    .cke           (cke),
    .rasN          (rasN),
    .casN          (casN),
    .weN           (weN),
    .addr          (addr),
    .initDone      (initDone)
  );

endmodule

// File: rtl/sdram_seq_checker.sv
`timescale 1ns/1ps
module sdram_seq_checker #(
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned REF_W  = 12,
  parameter int unsigned AP_BIT = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic [ROW_W-1:0] addr,
  input logic             ba,
  input logic             initDone,
  input logic [REF_W-1:0] refInterval
);

  localparam int unsigned GAP_W = REF_W + 5;

  logic [2:0]       cmd;
  logic [GAP_W-1:0] gapCnt;

  assign cmd = {rasN, casN, weN};

  // cycles since completion or since the last periodic refresh
  always_ff @(posedge clk) begin
    if (rst || !initDone)    gapCnt <= '0;
    else if (cmd == 3'b001)  gapCnt <= GAP_W'(1);
    else                     gapCnt <= gapCnt + GAP_W'(1);
  end

  assert_legal_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    !csN && (cmd == 3'b111 || cmd == 3'b010 || cmd == 3'b001 || cmd == 3'b000));

  assert_cke_hold_R1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_nop_at_cke_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (cmd == 3'b111));

  assert_precharge_all_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b010) |-> (addr[AP_BIT] && !ba && !initDone));

  assert_mode_single_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b000) |-> (!ba && !initDone));

  assert_mode_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b000) |=> (cmd != 3'b000));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_ref_period_R8: assert property (@(posedge clk) disable iff (rst)
    (initDone && cmd == 3'b001) |-> (gapCnt == {1'b0, $past(refInterval), 4'b0000}));

  assert_ref_off_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(initDone) && initDone && $past(refInterval) == '0) |-> (cmd == 3'b111));

endmodule

bind sdram_init_refresh_seq sdram_seq_checker #(
  .ROW_W  (ROW_W),
  .REF_W  (REF_W),
  .AP_BIT (AP_BIT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .csN         (csN),
  .rasN        (rasN),
  .casN        (casN),
  .weN         (weN),
  .addr        (addr),
  .ba          (ba),
  .initDone    (initDone),
  .refInterval (refInterval)
);

// File: tb/sdram_init_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_tb_top;

  localparam int INIT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] powerUpCycles = 16'd1;
  logic [7:0]  tRpCycles = '0;
  logic [7:0]  tRfcCycles = '0;
  logic [7:0]  tMrdCycles = '0;
  logic [11:0] refInterval = '0;
  logic [2:0]  casLatency = 3'd2;
  logic [2:0]  burstCode = 3'd3;
  logic        cke, csN, rasN, casN, weN, ba, initDone;
  logic [10:0] addr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdram_init_refresh_seq #(.INIT_REFRESHES(INIT)) dut_i (
    .clk(clk), .rst(rst), .powerUpCycles(powerUpCycles), .tRpCycles(tRpCycles),
    .tRfcCycles(tRfcCycles), .tMrdCycles(tMrdCycles), .refInterval(refInterval),
    .casLatency(casLatency), .burstCode(burstCode), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr), .ba(ba), .initDone(initDone)
  );

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Checks cycles 0..D+extra; caller leaves us in cycle 0. extra < 0 picks a default.
  task automatic runSeq(input int extra, input bit afterCollision);
    int pe, pc, rf1, g, m, d, per, last, badCs;
    logic [17:0] got, exp;
    logic [2:0]  eCmd;
    logic [10:0] eAddr;
    string       tag;
    pe    = (powerUpCycles == 0) ? 1 : int'(powerUpCycles);
    pc    = pe + 1;
    rf1   = pc + int'(tRpCycles) + 1;
    g     = (tRfcCycles > 15) ? int'(tRfcCycles) : 15;
    m     = rf1 + INIT * (g + 1);
    d     = m + int'(tMrdCycles) + 1;
    per   = 16 * int'(refInterval);
    last  = (extra >= 0) ? d + extra : ((per != 0) ? d + 3 * per + 2 : d + 70);
    badCs = 0;
    for (int c = 0; c <= last; c++) begin
      if (c > 0) begin
        @(posedge clk);
        #1;
      end
      eCmd  = 3'b111;
      eAddr = '0;
      if (c == 0)       tag = afterCollision ? "R10" : "R1";
      else if (c <= pe) tag = "R2";
      else if (c == pc) begin tag = "R3"; eCmd = 3'b010; eAddr = 11'h400; end
      else if (c < m) begin
        tag = (c <= rf1) ? "R4" : "R5";
        if (c >= rf1 && ((c - rf1) % (g + 1)) == 0) eCmd = 3'b001;
      end
      else if (c == m) begin
        tag = "R6"; eCmd = 3'b000; eAddr = {4'b0000, casLatency, 1'b0, burstCode};
      end
      else if (c < d)   tag = "R7";
      else begin
        tag = (per == 0) ? "R9" : "R8";
        if (c == d) tag = "R7";
        if (per != 0 && c > d && ((c - d) % per) == 0) eCmd = 3'b001;
      end
      exp = {(c != 0), 1'b0, eCmd, 1'b0, eAddr, (c >= d)};
      got = {cke, csN, rasN, casN, weN, ba, addr, initDone};
      report(got === exp, tag, $sformatf("cycle %0d {cke,csN,cmd,ba,addr,done}", c), got, exp);
      if (csN !== 1'b0) badCs++;
    end
    report(badCs == 0, "R11", "chip select high cycles", 18'(badCs), 18'd0);
  endtask

  initial begin
    int idx;
    idx = 0;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < 2; f++)
          for (int h = 0; h < 2; h++)
            for (int r = 0; r < 3; r++) begin
              rst           = 1'b1;
              powerUpCycles = (a == 0) ? 16'd1 : 16'd5;
              tRpCycles     = (b == 0) ? 8'd0 : 8'd2;
              tRfcCycles    = (f == 0) ? 8'd4 : 8'd19;
              tMrdCycles    = (h == 0) ? 8'd0 : 8'd3;
              refInterval   = (r == 0) ? 12'd1 : ((r == 1) ? 12'd0 : 12'd2);
              casLatency    = 3'(2 + (idx % 2));
              burstCode     = 3'((idx % 3 == 0) ? 3 : (idx % 3));
              idx++;
              doReset();
              runSeq(-1, 1'b0);
            end

    // power-up count of zero behaves as one; CAS 2 with burst code 3 gives 0x023
    rst = 1'b1;
    powerUpCycles = 16'd0; tRpCycles = 8'd1; tRfcCycles = 8'd15; tMrdCycles = 8'd2;
    refInterval = 12'd3; casLatency = 3'd2; burstCode = 3'd3;
    doReset();
    runSeq(-1, 1'b0);

    // R10: reset on the edge that would launch the second periodic refresh
    rst = 1'b1;
    powerUpCycles = 16'd3; tRpCycles = 8'd2; tRfcCycles = 8'd16; tMrdCycles = 8'd1;
    refInterval = 12'd1; casLatency = 3'd3; burstCode = 3'd2;
    doReset();
    runSeq(2 * 16 - 1, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    runSeq(-1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule